// File: doc/BRIEF.md
# Banked L1 Access Delay Pipeline

This block sits between the pending access queue of a load/store unit and a multi-bank L1 data cache. Each bank owns a short delay line. Requests are taken from the back of the queue, at most one per bank per cycle, and each is written into the tail slot of the bank chosen by its address bits. An entry then moves one stage towards the head on each cycle in which the stage ahead of it is empty. The head slot of each bank is shown to the cache, and the cache's response decides whether the entry leaves the line or stays to be tried again.

The issuer learns through a two-bit stall code whether a bank conflict stopped it or whether requests are simply still waiting. The block also keeps two sets of counters. One holds outstanding store sectors per warp. The other holds pending register writes per warp and register. For the second set, a release bit pulses when a load hit drains a count to zero.

The design has two small enumerated machines. The cache response decoder has the states HIT, MISS, HIT_RSV and RSV_FAIL. The issue outcome has the states NONE, BANK and COAL. Each head slot moves between empty and occupied. The transitions are: occupied to empty on HIT, MISS or HIT_RSV; occupied to occupied on RSV_FAIL; empty to occupied by compaction from the next stage or by tail insertion.

Top module: `l1_bank_delay`

## Requirements
- R1: After a synchronous active-high reset, every slot is empty (`hd_valid` all zero) and every counter is zero. `st_ack`, `st_drained` and `rel_mask` are zero. With `q_len` zero, `pop_cnt` is 0 and `stall` is 2'b00.
- R2: The bank of a request is `addr[LINE_BITS +: log2(NB)]`. A request accepted in cycle c, with an empty line ahead of it, is shown as that bank's head in cycle c+DEPTH with its address on `hd_addr`.
- R3: Request index 0 is the back of the queue and is tried first. Up to NB requests with index below `q_len` are accepted in one cycle, each into a different bank, and `pop_cnt` gives how many.
- R4: If a tried request finds its bank's tail slot occupied, or already claimed earlier in the same cycle, `stall` is 2'b01. That request and every later one are not accepted in that cycle, even when their banks are free.
- R5: With no conflict, `stall` is 2'b10 when `q_len` exceeds `pop_cnt`, and 2'b00 otherwise.
- R6: `cache_resp` per bank uses 2 bits: 00 hit, 01 miss, 10 hit on a reserved line, 11 reservation failure. On 00, 01 or 10 the head entry leaves. On 11 it stays with the same address.
- R7: Within a cycle, head retirement comes first. Compaction from stage 0 up to DEPTH-2 follows, and each empty stage takes the next stage's entry. Tail insertion comes last and sees the tail as it is after compaction. A retiring head is replaced in the next cycle with no bubble, and each entry advances at most one stage per cycle.
- R8: An accepted store adds `rq_bytes/SECTOR_BYTES` (sector mode) or 1 (otherwise) to its warp's count on `st_cnt` (warp w at bits `[w*CNT_W +: CNT_W]`), visible from the next cycle.
- R9: A store head answered with hit while `cache_wr_sent` is low pulses `st_ack` for that bank in the same cycle and subtracts the same amount from the warp's count. `st_drained[w]` pulses when this brings the count to zero. A hit with `cache_wr_sent` high, or a miss, gives no acknowledge and no subtraction.
- R10: An accepted load adds 1 to the pending count of its warp and register. A load head answered with hit subtracts 1. When the count reaches zero, `rel_mask` bit `warp*REGS+reg` pulses in that same cycle.
- R11: No counter ever drops below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_len | input | QL_W | Number of entries waiting in the access queue |
| rq_addr | input | NB*ADDR_W | Addresses of the NB entries nearest the back, index 0 first |
| rq_store | input | NB | Store flag per offered entry |
| rq_warp | input | NB*log2(WARPS) | Issuing warp per offered entry |
| rq_reg | input | NB*log2(REGS) | Destination register per offered entry |
| rq_bytes | input | NB*SIZE_W | Access size in bytes per offered entry |
| pop_cnt | output | log2(NB+1) | Entries accepted this cycle |
| stall | output | 2 | 00 none, 01 bank conflict, 10 queue not drained |
| hd_valid | output | NB | Head slot occupied, per bank |
| hd_addr | output | NB*ADDR_W | Head address per bank |
| hd_store | output | NB | Head is a store, per bank |
| cache_resp | input | 2*NB | Cache response per bank head |
| cache_wr_sent | input | NB | Cache forwarded a write downstream for this head |
| st_ack | output | NB | Store acknowledge pulse per bank |
| st_cnt | output | WARPS*CNT_W | Outstanding store sectors per warp |
| st_drained | output | WARPS | Warp store count reached zero this cycle |
| rel_mask | output | WARPS*REGS | Register release pulses |

## Verification
The accept path is driven with single requests, with pairs split across both banks, with pairs aimed at one bank, and with a queue longer than the bank count. These patterns separate the clean, coalescing and conflict outcomes, and show that a blocked back entry stops a later one bound for a free bank. One bank's line is filled while its head is held by reservation failures. This shows the tail freeing in the same cycle as a head retirement, and the one-stage-per-cycle walk that follows. The store tests compare a write-back hit with a forwarded write and check the multi-sector increment. The load tests compare a hit that leaves a nonzero count with one that drains it.

// File: rtl/l1bd_pkg.sv
package l1bd_pkg;

    typedef enum logic [1:0] {
        RSP_HIT      = 2'b00,
        RSP_MISS     = 2'b01,
        RSP_HIT_RSV  = 2'b10,
        RSP_RSV_FAIL = 2'b11
    } cache_rsp_e;

    typedef enum logic [1:0] {
        STL_NONE = 2'b00,
        STL_BANK = 2'b01,
        STL_COAL = 2'b10
    } stall_e;

endpackage

// File: rtl/l1bd_lane.sv
module l1bd_lane
    import l1bd_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cache_rsp_e       rsp,
    input  logic             ins_v,
    input  logic [PAY_W-1:0] ins_pay,
    output logic             head_v,
    output logic [PAY_W-1:0] head_pay,
    output logic             tail_free
);

    logic [DEPTH-1:0] vld_q, vld_c, vld_d;
    logic [PAY_W-1:0] pay_q [DEPTH];
    logic [PAY_W-1:0] pay_c [DEPTH];
    logic [PAY_W-1:0] pay_d [DEPTH];
    logic             head_go;

    assign head_v   = vld_q[0];
    assign head_pay = pay_q[0];

    // head decision from the cache response
    always_comb begin
        unique case (rsp)
            RSP_HIT, RSP_MISS, RSP_HIT_RSV: head_go = vld_q[0];
            RSP_RSV_FAIL:                   head_go = 1'b0;
        endcase
    end

    // retire head, then close bubbles walking from the head upward
    always_comb begin
        vld_c = vld_q;
        pay_c = pay_q;
        if (head_go) vld_c[0] = 1'b0;
        for (int s = 0; s < DEPTH - 1; s++) begin
            if (!vld_c[s]) begin
                vld_c[s]     = vld_c[s+1];
                pay_c[s]     = pay_c[s+1];
                vld_c[s+1]   = 1'b0;
            end
        end
    end

    assign tail_free = !vld_c[DEPTH-1];

    always_comb begin
        vld_d = vld_c;
        pay_d = pay_c;
        if (ins_v) begin
            vld_d[DEPTH-1] = 1'b1;
            pay_d[DEPTH-1] = ins_pay;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int k = 0; k < DEPTH; k++) pay_q[k] <= '0;
        end else begin
            vld_q <= vld_d;
            pay_q <= pay_d;
        end
    end

endmodule

// File: rtl/l1bd_accept.sv
module l1bd_accept
    import l1bd_pkg::*;
#(
    parameter int NB     = 2,
    parameter int BANK_W = 1,
    parameter int QL_W   = 4,
    parameter int PC_W   = 2
) (
    input  logic [QL_W-1:0]      q_len,
    input  logic [NB*BANK_W-1:0] bank_sel,
    input  logic [NB-1:0]        tail_free,
    output logic [NB-1:0]        take,
    output logic [PC_W-1:0]      pop_cnt,
    output stall_e               stall
);

    logic [NB-1:0]     room;
    logic              halt;
    logic              clash;
    logic [BANK_W-1:0] bsel;

    always_comb begin
        room    = tail_free;
        halt    = 1'b0;
        clash   = 1'b0;
        take    = '0;
        pop_cnt = '0;
        bsel    = '0;
        for (int i = 0; i < NB; i++) begin
            bsel = bank_sel[i*BANK_W +: BANK_W];
            if (!halt && (i < int'(q_len))) begin
                if (room[bsel]) begin
                    take[i]    = 1'b1;
                    room[bsel] = 1'b0;
                    pop_cnt    = pop_cnt + PC_W'(1);
                end else begin
                    clash = 1'b1;
                    halt  = 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (clash)                         stall = STL_BANK;
        else if (int'(q_len) > int'(pop_cnt)) stall = STL_COAL;
        else                               stall = STL_NONE;
    end

endmodule

// File: rtl/l1bd_tally.sv
module l1bd_tally #(
    parameter int N     = 4,
    parameter int CNT_W = 6,
    parameter int NEV   = 2,
    parameter int IDX_W = 2,
    parameter int AMT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NEV-1:0]       inc_v,
    input  logic [NEV*IDX_W-1:0] inc_idx,
    input  logic [NEV*AMT_W-1:0] inc_amt,
    input  logic [NEV-1:0]       dec_v,
    input  logic [NEV*IDX_W-1:0] dec_idx,
    input  logic [NEV*AMT_W-1:0] dec_amt,
    output logic [N*CNT_W-1:0]   cnt,
    output logic [N-1:0]         zero_hit,
    output logic [N-1:0]         under
);

    localparam int MX_W  = (CNT_W > AMT_W) ? CNT_W : AMT_W;
    localparam int SUM_W = MX_W + $clog2(NEV + 1) + 1;

    logic [CNT_W-1:0] cnt_q  [N];
    logic [CNT_W-1:0] cnt_d  [N];
    logic [SUM_W-1:0] up_s   [N];
    logic [SUM_W-1:0] dn_s   [N];
    logic [SUM_W-1:0] base_s [N];

    always_comb begin
        for (int k = 0; k < N; k++) begin
            up_s[k] = '0;
            dn_s[k] = '0;
            for (int e = 0; e < NEV; e++) begin
                if (inc_v[e] && inc_idx[e*IDX_W +: IDX_W] == IDX_W'(k))
                    up_s[k] = up_s[k] + SUM_W'(inc_amt[e*AMT_W +: AMT_W]);
                if (dec_v[e] && dec_idx[e*IDX_W +: IDX_W] == IDX_W'(k))
                    dn_s[k] = dn_s[k] + SUM_W'(dec_amt[e*AMT_W +: AMT_W]);
            end
            base_s[k]   = SUM_W'(cnt_q[k]) + up_s[k];
            under[k]    = base_s[k] < dn_s[k];
            zero_hit[k] = (dn_s[k] != '0) && (base_s[k] == dn_s[k]);
            cnt_d[k]    = CNT_W'(base_s[k] - dn_s[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) cnt_q[k] <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign cnt[g*CNT_W +: CNT_W] = cnt_q[g];
    end

endmodule

// File: rtl/l1_bank_delay.sv
module l1_bank_delay
    import l1bd_pkg::*;
#(
    parameter int NB           = 2,
    parameter int DEPTH        = 3,
    parameter int ADDR_W       = 16,
    parameter int LINE_BITS    = 5,
    parameter int WARPS        = 4,
    parameter int REGS         = 8,
    parameter int SIZE_W       = 8,
    parameter int SECTOR_BYTES = 32,
    parameter int SECTOR_MODE  = 1,
    parameter int CNT_W        = 6,
    parameter int QL_W         = 4,
    localparam int BANK_W      = (NB > 1) ? $clog2(NB) : 1,
    localparam int WID_W       = $clog2(WARPS),
    localparam int RID_W       = $clog2(REGS),
    localparam int PC_W        = $clog2(NB + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [QL_W-1:0]         q_len,
    input  logic [NB*ADDR_W-1:0]    rq_addr,
    input  logic [NB-1:0]           rq_store,
    input  logic [NB*WID_W-1:0]     rq_warp,
    input  logic [NB*RID_W-1:0]     rq_reg,
    input  logic [NB*SIZE_W-1:0]    rq_bytes,
    output logic [PC_W-1:0]         pop_cnt,
    output logic [1:0]              stall,
    output logic [NB-1:0]           hd_valid,
    output logic [NB*ADDR_W-1:0]    hd_addr,
    output logic [NB-1:0]           hd_store,
    input  logic [2*NB-1:0]         cache_resp,
    input  logic [NB-1:0]           cache_wr_sent,
    output logic [NB-1:0]           st_ack,
    output logic [WARPS*CNT_W-1:0]  st_cnt,
    output logic [WARPS-1:0]        st_drained,
    output logic [WARPS*REGS-1:0]   rel_mask
);

    localparam int AMT_W = SIZE_W;
    localparam int NPW   = WARPS * REGS;
    localparam int PW_W  = WID_W + RID_W;
    localparam int PAY_W = ADDR_W + 1 + WID_W + RID_W + AMT_W;
    localparam int O_REG = AMT_W;
    localparam int O_WID = AMT_W + RID_W;
    localparam int O_ST  = AMT_W + RID_W + WID_W;
    localparam int O_AD  = O_ST + 1;

    logic [BANK_W-1:0]    rq_bank [NB];
    logic [NB*BANK_W-1:0] bank_flat;
    logic [AMT_W-1:0]     rq_amt  [NB];
    logic [NB*AMT_W-1:0]  rq_amt_flat;
    logic [PAY_W-1:0]     rq_pay  [NB];
    logic [NB*PW_W-1:0]   rq_pw_flat;

    logic [NB-1:0]        take;
    logic [NB-1:0]        tail_free;
    stall_e               stall_w;
    logic [NB-1:0]        ins_v;
    logic [PAY_W-1:0]     ins_pay [NB];
    logic [PAY_W-1:0]     hd_pay  [NB];
    cache_rsp_e           rsp_b   [NB];

    logic [NB*WID_W-1:0]  hd_warp_flat;
    logic [NB*AMT_W-1:0]  hd_amt_flat;
    logic [NB*PW_W-1:0]   hd_pw_flat;
    logic [NB-1:0]        ld_hit;
    logic [WARPS-1:0]     st_under;
    logic [NPW-1:0]       pw_under;

    // request side decode
    for (genvar i = 0; i < NB; i++) begin : g_req
        if (NB == 1) begin : g_one
            assign rq_bank[i] = '0;
        end else begin : g_sel
            assign rq_bank[i] = rq_addr[i*ADDR_W + LINE_BITS +: BANK_W];
        end
        if (SECTOR_MODE != 0) begin : g_sec
            assign rq_amt[i] = AMT_W'(rq_bytes[i*SIZE_W +: SIZE_W] / SECTOR_BYTES);
        end else begin : g_unit
            assign rq_amt[i] = AMT_W'(1);
        end
        assign bank_flat[i*BANK_W +: BANK_W] = rq_bank[i];
        assign rq_amt_flat[i*AMT_W +: AMT_W] = rq_amt[i];
        assign rq_pw_flat[i*PW_W +: PW_W]    = {rq_warp[i*WID_W +: WID_W],
                                                rq_reg[i*RID_W +: RID_W]};
        assign rq_pay[i] = {rq_addr[i*ADDR_W +: ADDR_W], rq_store[i],
                            rq_warp[i*WID_W +: WID_W], rq_reg[i*RID_W +: RID_W],
                            rq_amt[i]};
    end

    l1bd_accept #(
        .NB(NB), .BANK_W(BANK_W), .QL_W(QL_W), .PC_W(PC_W)
    ) u_accept (
        .q_len    (q_len),
        .bank_sel (bank_flat),
        .tail_free(tail_free),
        .take     (take),
        .pop_cnt  (pop_cnt),
        .stall    (stall_w)
    );

    assign stall = stall_w;

    // route accepted requests to their banks (at most one per bank)
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            ins_v[b]   = 1'b0;
            ins_pay[b] = '0;
            for (int i = 0; i < NB; i++) begin
                if (take[i] && rq_bank[i] == BANK_W'(b)) begin
                    ins_v[b]   = 1'b1;
                    ins_pay[b] = rq_pay[i];
                end
            end
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign rsp_b[b] = cache_rsp_e'(cache_resp[2*b +: 2]);

        l1bd_lane #(
            .DEPTH(DEPTH), .PAY_W(PAY_W)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .rsp      (rsp_b[b]),
            .ins_v    (ins_v[b]),
            .ins_pay  (ins_pay[b]),
            .head_v   (hd_valid[b]),
            .head_pay (hd_pay[b]),
            .tail_free(tail_free[b])
        );

        assign hd_addr[b*ADDR_W +: ADDR_W]  = hd_pay[b][O_AD +: ADDR_W];
        assign hd_store[b]                  = hd_pay[b][O_ST];
        assign hd_warp_flat[b*WID_W +: WID_W] = hd_pay[b][O_WID +: WID_W];
        assign hd_amt_flat[b*AMT_W +: AMT_W]  = hd_pay[b][AMT_W-1:0];
        assign hd_pw_flat[b*PW_W +: PW_W]     = {hd_pay[b][O_WID +: WID_W],
                                                 hd_pay[b][O_REG +: RID_W]};

        assign st_ack[b] = hd_valid[b] && (rsp_b[b] == RSP_HIT) && hd_store[b]
                           && !cache_wr_sent[b];
        assign ld_hit[b] = hd_valid[b] && (rsp_b[b] == RSP_HIT) && !hd_store[b];
    end

    l1bd_tally #(
        .N(WARPS), .CNT_W(CNT_W), .NEV(NB), .IDX_W(WID_W), .AMT_W(AMT_W)
    ) u_st_tally (
        .clk     (clk),
        .rst     (rst),
        .inc_v   (take & rq_store),
        .inc_idx (rq_warp),
        .inc_amt (rq_amt_flat),
        .dec_v   (st_ack),
        .dec_idx (hd_warp_flat),
        .dec_amt (hd_amt_flat),
        .cnt     (st_cnt),
        .zero_hit(st_drained),
        .under   (st_under)
    );

    l1bd_tally #(
        .N(NPW), .CNT_W(CNT_W), .NEV(NB), .IDX_W(PW_W), .AMT_W(1)
    ) u_pw_tally (
        .clk     (clk),
        .rst     (rst),
        .inc_v   (take & ~rq_store),
        .inc_idx (rq_pw_flat),
        .inc_amt ({NB{1'b1}}),
        .dec_v   (ld_hit),
        .dec_idx (hd_pw_flat),
        .dec_amt ({NB{1'b1}}),
        .cnt     (),
        .zero_hit(rel_mask),
        .under   (pw_under)
    );

endmodule

// File: rtl/l1_bank_delay_chk.sv
module l1_bank_delay_chk #(
    parameter int NB     = 2,
    parameter int ADDR_W = 16,
    parameter int QL_W   = 4,
    parameter int PC_W   = 2,
    parameter int WARPS  = 4,
    parameter int NPW    = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [QL_W-1:0]      q_len,
    input logic [PC_W-1:0]      pop_cnt,
    input logic [1:0]           stall,
    input logic [NB-1:0]        hd_valid,
    input logic [NB*ADDR_W-1:0] hd_addr,
    input logic [NB-1:0]        hd_store,
    input logic [2*NB-1:0]      cache_resp,
    input logic [NB-1:0]        st_ack,
    input logic [WARPS-1:0]     st_under,
    input logic [NPW-1:0]       pw_under
);

    a_r1_empty_after_reset: assert property (@(posedge clk)
        $past(rst) |-> hd_valid == '0);

    a_r3_pop_bound: assert property (@(posedge clk) disable iff (rst)
        (int'(pop_cnt) <= NB) && (int'(pop_cnt) <= int'(q_len)));

    a_r4_conflict_short: assert property (@(posedge clk) disable iff (rst)
        stall == 2'b01 |-> (int'(pop_cnt) < int'(q_len)) && (int'(pop_cnt) < NB));

    a_r5_coal_full: assert property (@(posedge clk) disable iff (rst)
        stall == 2'b10 |-> (int'(pop_cnt) == NB) && (int'(q_len) > NB));

    a_r5_code_legal: assert property (@(posedge clk) disable iff (rst)
        stall != 2'b11);

    a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (st_under == '0) && (pw_under == '0));

    for (genvar b = 0; b < NB; b++) begin : g_chk
        a_r6_hold_on_fail: assert property (@(posedge clk) disable iff (rst)
            hd_valid[b] && cache_resp[2*b +: 2] == 2'b11
            |=> hd_valid[b] && $stable(hd_addr[b*ADDR_W +: ADDR_W]));

        a_r9_ack_needs_hit: assert property (@(posedge clk) disable iff (rst)
            st_ack[b] |-> hd_valid[b] && hd_store[b] && cache_resp[2*b +: 2] == 2'b00);
    end

endmodule

bind l1_bank_delay l1_bank_delay_chk #(
    .NB(NB), .ADDR_W(ADDR_W), .QL_W(QL_W), .PC_W(PC_W),
    .WARPS(WARPS), .NPW(NPW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .q_len     (q_len),
    .pop_cnt   (pop_cnt),
    .stall     (stall),
    .hd_valid  (hd_valid),
    .hd_addr   (hd_addr),
    .hd_store  (hd_store),
    .cache_resp(cache_resp),
    .st_ack    (st_ack),
    .st_under  (st_under),
    .pw_under  (pw_under)
);

// File: tb/l1_bank_delay_test.sv
module l1_bank_delay_test;

    localparam int NB = 2, ADDR_W = 16, WID_W = 2, RID_W = 3, SIZE_W = 8;
    localparam int CNT_W = 6, QL_W = 4, PC_W = 2, WARPS = 4, REGS = 8;

    logic                   clk = 1'b0;
    logic                   rst;
    logic [QL_W-1:0]        q_len;
    logic [NB*ADDR_W-1:0]   rq_addr;
    logic [NB-1:0]          rq_store;
    logic [NB*WID_W-1:0]    rq_warp;
    logic [NB*RID_W-1:0]    rq_reg;
    logic [NB*SIZE_W-1:0]   rq_bytes;
    logic [PC_W-1:0]        pop_cnt;
    logic [1:0]             stall;
    logic [NB-1:0]          hd_valid;
    logic [NB*ADDR_W-1:0]   hd_addr;
    logic [NB-1:0]          hd_store;
    logic [2*NB-1:0]        cache_resp;
    logic [NB-1:0]          cache_wr_sent;
    logic [NB-1:0]          st_ack;
    logic [WARPS*CNT_W-1:0] st_cnt;
    logic [WARPS-1:0]       st_drained;
    logic [WARPS*REGS-1:0]  rel_mask;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    l1_bank_delay uut (
        .clk(clk), .rst(rst), .q_len(q_len), .rq_addr(rq_addr),
        .rq_store(rq_store), .rq_warp(rq_warp), .rq_reg(rq_reg),
        .rq_bytes(rq_bytes), .pop_cnt(pop_cnt), .stall(stall),
        .hd_valid(hd_valid), .hd_addr(hd_addr), .hd_store(hd_store),
        .cache_resp(cache_resp), .cache_wr_sent(cache_wr_sent),
        .st_ack(st_ack), .st_cnt(st_cnt), .st_drained(st_drained),
        .rel_mask(rel_mask)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        q_len         = '0;
        rq_addr       = '0;
        rq_store      = '0;
        rq_warp       = '0;
        rq_reg        = '0;
        rq_bytes      = '0;
        cache_resp    = {NB{2'b01}};
        cache_wr_sent = '0;
    endtask

    task automatic put_req(input int i, input int addr, input bit st,
                           input int w, input int r, input int bytes);
        rq_addr[i*ADDR_W +: ADDR_W] = ADDR_W'(addr);
        rq_store[i]                 = st;
        rq_warp[i*WID_W +: WID_W]   = WID_W'(w);
        rq_reg[i*RID_W +: RID_W]    = RID_W'(r);
        rq_bytes[i*SIZE_W +: SIZE_W] = SIZE_W'(bytes);
    endtask

    task automatic set_rsp(input int b, input logic [1:0] code, input bit ws);
        cache_resp[2*b +: 2] = code;
        cache_wr_sent[b]     = ws;
    endtask

    function automatic longint hd_a(input int b);
        return longint'(hd_addr[b*ADDR_W +: ADDR_W]);
    endfunction

    function automatic longint cnt_of(input int w);
        return longint'(st_cnt[w*CNT_W +: CNT_W]);
    endfunction

    task automatic settle();
        #2;
    endtask

    task automatic next_cyc();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic drain();
        idle_inputs();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        chk("R1 hd_valid", hd_valid, 0);
        chk("R1 stall", stall, 0);
        chk("R1 pop_cnt", pop_cnt, 0);
        chk("R1 st_cnt", st_cnt, 0);
        chk("R1 rel_mask", rel_mask, 0);
        chk("R1 st_ack", st_ack, 0);
        next_cyc();
    endtask

    task automatic t_latency();
        q_len = 1;
        put_req(0, 'h0020, 0, 1, 2, 4);
        settle();
        chk("R3 single pop", pop_cnt, 1);
        chk("R5 single no stall", stall, 0);
        next_cyc(); settle();
        chk("R2 not yet c1", hd_valid, 0);
        next_cyc(); settle();
        chk("R2 not yet c2", hd_valid, 0);
        next_cyc();
        set_rsp(1, 2'b00, 0);
        settle();
        chk("R2 head bank1", hd_valid, 2'b10);
        chk("R2 head addr", hd_a(1), 'h0020);
        chk("R10 release w1r2", rel_mask, 64'(1) << 10);
        chk("R9 no ack for load", st_ack, 0);
        next_cyc(); settle();
        chk("R6 hit retired", hd_valid, 0);
        chk("R10 pulse ends", rel_mask, 0);
        drain();
    endtask

    task automatic t_two_banks();
        q_len = 2;
        put_req(0, 'h0000, 0, 0, 1, 4);
        put_req(1, 'h0020, 0, 0, 1, 4);
        settle();
        chk("R3 pair split pop", pop_cnt, 2);
        chk("R5 pair clean", stall, 0);
        next_cyc();
        q_len = 3;
        put_req(0, 'h0040, 0, 0, 1, 4);
        put_req(1, 'h0060, 0, 0, 1, 4);
        settle();
        chk("R3 long queue pop", pop_cnt, 2);
        chk("R5 coalesce stall", stall, 2'b10);
        next_cyc();
        q_len = 2;
        put_req(0, 'h0080, 0, 0, 1, 4);
        put_req(1, 'h00A0, 0, 0, 1, 4);
        settle();
        chk("R7 tail freed by advance", pop_cnt, 2);
        drain();
        q_len = 2;
        put_req(0, 'h0000, 0, 0, 1, 4);
        put_req(1, 'h0040, 0, 0, 1, 4);
        settle();
        chk("R4 same bank pop", pop_cnt, 1);
        chk("R4 same bank stall", stall, 2'b01);
        drain();
    endtask

    task automatic t_fill_hold();
        q_len = 1; put_req(0, 'h0000, 0, 0, 3, 4); settle();
        chk("R3 fill A", pop_cnt, 1);
        next_cyc();
        q_len = 1; put_req(0, 'h0040, 0, 0, 3, 4); settle();
        chk("R7 fill B back to back", pop_cnt, 1);
        next_cyc();
        q_len = 1; put_req(0, 'h0080, 0, 0, 3, 4); settle();
        chk("R7 fill C back to back", pop_cnt, 1);
        next_cyc();
        set_rsp(0, 2'b11, 0);
        q_len = 2;
        put_req(0, 'h00C0, 0, 0, 3, 4);
        put_req(1, 'h0020, 0, 0, 3, 4);
        settle();
        chk("R2 head A", hd_a(0), 'h0000);
        chk("R4 full bank pop", pop_cnt, 0);
        chk("R4 full bank stall", stall, 2'b01);
        next_cyc();
        set_rsp(0, 2'b11, 0);
        settle();
        chk("R6 held valid", hd_valid[0], 1);
        chk("R6 held addr", hd_a(0), 'h0000);
        next_cyc();
        set_rsp(0, 2'b00, 0);
        q_len = 1; put_req(0, 'h00C0, 0, 0, 3, 4);
        settle();
        chk("R6 still A before hit", hd_a(0), 'h0000);
        chk("R10 partial no release", rel_mask, 0);
        chk("R7 tail after compaction", pop_cnt, 1);
        chk("R7 no stall", stall, 0);
        next_cyc(); settle();
        chk("R7 no bubble B", hd_a(0), 'h0040);
        chk("R4 later entry skipped", hd_valid[1], 0);
        next_cyc(); settle();
        chk("R7 next C", hd_a(0), 'h0080);
        next_cyc(); settle();
        chk("R7 D one stage per cycle", hd_a(0), 'h00C0);
        chk("R7 D valid", hd_valid[0], 1);
        drain();
    endtask

    task automatic t_stores();
        q_len = 1; put_req(0, 'h0020, 1, 2, 0, 64); settle();
        chk("R8 store pop", pop_cnt, 1);
        next_cyc();
        q_len = 1; put_req(0, 'h0060, 1, 2, 0, 32); settle();
        chk("R8 two sectors", cnt_of(2), 2);
        next_cyc(); settle();
        chk("R8 three sectors", cnt_of(2), 3);
        next_cyc();
        set_rsp(1, 2'b00, 0);
        settle();
        chk("R9 ack on wb hit", st_ack, 2'b10);
        chk("R9 not drained", st_drained, 0);
        next_cyc();
        set_rsp(1, 2'b00, 1);
        settle();
        chk("R9 count after ack", cnt_of(2), 1);
        chk("R9 no ack when write sent", st_ack, 0);
        next_cyc(); settle();
        chk("R9 no decrement when sent", cnt_of(2), 1);
        drain();
        q_len = 1; put_req(0, 'h0000, 1, 1, 0, 32); settle();
        next_cyc();
        next_cyc();
        next_cyc();
        set_rsp(0, 2'b01, 0);
        settle();
        chk("R9 miss no ack", st_ack, 0);
        drain();
        chk("R9 miss keeps count", cnt_of(1), 1);
        q_len = 1; put_req(0, 'h0000, 1, 3, 0, 32); settle();
        next_cyc(); settle();
        chk("R8 warp3 count", cnt_of(3), 1);
        next_cyc();
        next_cyc();
        set_rsp(0, 2'b00, 0);
        settle();
        chk("R9 ack bank0", st_ack, 2'b01);
        chk("R9 drained warp3", st_drained, 4'b1000);
        next_cyc(); settle();
        chk("R9 warp3 zero", cnt_of(3), 0);
        drain();
    endtask

    task automatic t_loads();
        q_len = 1; put_req(0, 'h0000, 0, 3, 5, 4); settle();
        next_cyc();
        q_len = 1; put_req(0, 'h0040, 0, 3, 5, 4); settle();
        next_cyc();
        next_cyc();
        set_rsp(0, 2'b00, 0);
        settle();
        chk("R10 first hit no release", rel_mask, 0);
        next_cyc();
        set_rsp(0, 2'b00, 0);
        settle();
        chk("R10 second hit head", hd_a(0), 'h0040);
        chk("R10 release w3r5", rel_mask, 64'(1) << 29);
        drain();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_two_banks();
        t_fill_hold();
        t_stores();
        t_loads();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule